// File: doc/BRIEF.md
# Age-Prioritized Out-of-Order Issue Queue

This block holds decoded instructions in a bank of slots until both of their source operands are available, then releases them one per cycle to an execution pipe. An instruction can leave from any slot, not only the head. When more than one instruction is ready, the queue always releases the one that was written first. Age is held in a relative-order matrix, so slot numbers say nothing about age. This stops an old instruction from being passed over again and again while younger ones keep issuing.

A dispatch stage writes up to four instructions per cycle into free slots. Each instruction carries two source tags with ready flags, a destination tag and a memory-class marker. Producers broadcast destination tags on a wakeup bus, and every waiting source with a matching tag becomes ready. The same module is used once per instruction class (integer, floating-point, memory). The integer copy can be built to take the address-generation half of a load or store while the memory queue is full. Such an entry issues with an address-only marker.

Top module: `iq_age_issue`

## Requirements
- R1: After reset no slot is occupied: `iss_valid` is 0 and `full` is 0.
- R2: An entry is issued only when both of its source ready flags are set. An entry with either source pending is never issued.
- R3: When several entries are ready, the issued one is the entry written earliest, whatever slot it occupies.
- R4: A wakeup whose tag equals a pending source tag sets that source ready. The entry can be issued at the earliest in the cycle after the wakeup. A wakeup with a different tag has no effect.
- R5: Up to `INS_W` instructions are written per cycle into the lowest-numbered free slots. Within one cycle, a lower-numbered lane counts as older.
- R6: `full` is 1 while fewer than `INS_W` slots are free. Writes presented while `full` is 1 are dropped.
- R7: A source whose tag matches a wakeup in the same cycle that it is written is stored as ready.
- R8: A lane with `ins_mem`=1 is accepted only when `ALLOW_ADDR_ONLY`=1 and `mem_q_full`=1. It then issues with `iss_addr_only`=1. Lanes with `ins_mem`=0 are always accepted (subject to R6) and issue with `iss_addr_only`=0.
- R9: At most one entry issues per cycle. An issued entry leaves its slot at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | INS_W | Per-lane write request |
| ins_src0 | input | INS_W*TAG_W | Per-lane first source tag |
| ins_src0_rdy | input | INS_W | Per-lane first source already available |
| ins_src1 | input | INS_W*TAG_W | Per-lane second source tag |
| ins_src1_rdy | input | INS_W | Per-lane second source already available |
| ins_dst | input | INS_W*TAG_W | Per-lane destination tag |
| ins_mem | input | INS_W | Per-lane memory-class instruction marker |
| mem_q_full | input | 1 | The memory-class queue cannot take more entries |
| wake_valid | input | WAKE_N | Per-port wakeup strobe |
| wake_tag | input | WAKE_N*TAG_W | Per-port wakeup tag |
| full | output | 1 | Fewer than INS_W free slots |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_dst | output | TAG_W | Destination tag of the issued entry |
| iss_addr_only | output | 1 | Issued entry is an address-only memory operation |

## Verification
The bench builds the queue with its defaults: 16 slots, four write lanes, two wakeup ports, 6-bit tags and address-only acceptance turned on. Sixteen slots with four lanes means four write cycles are enough to reach the full threshold. Two wakeup ports let two waiting entries become ready in the same cycle, so their age order decides which issues first. Reusing a freed low slot for a younger entry checks that age, not slot number, drives the choice.

// File: rtl/iq_pkg.sv
// Shared definitions for the issue queue.
// Assumes one tag width for the whole queue, fixed here.
package iq_pkg;
    parameter int IQ_TAG_W = 6;

    // One queued micro-operation, without its occupancy flag.
    typedef struct packed {
        logic [IQ_TAG_W-1:0] src0;
        logic                src0_rdy;
        logic [IQ_TAG_W-1:0] src1;
        logic                src1_rdy;
        logic [IQ_TAG_W-1:0] dst;
        logic                addr_only;
    } iq_uop_t;
endpackage

// File: rtl/iq_entry.sv
// One queue slot: stores a micro-op, snoops the wakeup bus and reports
// readiness. Assumes a write and a clear never target it in the same cycle.
module iq_entry
    import iq_pkg::*;
#(
    parameter int WAKE_N = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  iq_uop_t                    wr_uop,
    input  logic                       clr,
    input  logic [WAKE_N-1:0]          wake_valid,
    input  logic [WAKE_N*IQ_TAG_W-1:0] wake_tag,
    output logic                       valid,
    output logic                       ready,
    output iq_uop_t                    uop
);
    iq_uop_t base;
    logic    hit0, hit1;

    // Match the sources of the stored or incoming op against every wakeup port.
    always_comb begin
        base = wr ? wr_uop : uop;
        hit0 = 1'b0;
        hit1 = 1'b0;
        for (int p = 0; p < WAKE_N; p++) begin
            if (wake_valid[p] && wake_tag[p*IQ_TAG_W +: IQ_TAG_W] == base.src0) hit0 = 1'b1;
            if (wake_valid[p] && wake_tag[p*IQ_TAG_W +: IQ_TAG_W] == base.src1) hit1 = 1'b1;
        end
    end

    // Slot state: load on write, drop on issue, otherwise collect wakeups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            uop   <= '0;
        end else if (wr) begin
            valid        <= 1'b1;
            uop          <= base;
            uop.src0_rdy <= base.src0_rdy | hit0;
            uop.src1_rdy <= base.src1_rdy | hit1;
        end else begin
            if (clr) valid <= 1'b0;
            uop.src0_rdy <= uop.src0_rdy | hit0;
            uop.src1_rdy <= uop.src1_rdy | hit1;
        end
    end

    assign ready = valid & uop.src0_rdy & uop.src1_rdy;
endmodule

// File: rtl/iq_alloc.sv
// Free-slot allocator: gives each requesting lane, in lane order, the
// lowest free slot not already taken by a lower lane. Assumes callers
// gate requests with full, so every request finds a slot.
module iq_alloc #(
    parameter int DEPTH = 16,
    parameter int INS_W = 4
) (
    input  logic [DEPTH-1:0]            valid_vec,
    input  logic [INS_W-1:0]            lane_req,
    output logic [INS_W-1:0][DEPTH-1:0] slot_oh,
    output logic                        full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] free_cnt;
    logic [DEPTH-1:0] taken;
    logic             found;

    // Count free slots and derive the full indication.
    always_comb begin
        free_cnt = '0;
        for (int s = 0; s < DEPTH; s++) free_cnt = free_cnt + CNT_W'(!valid_vec[s]);
        full = (free_cnt < CNT_W'(INS_W));
    end

    // Hand out slots to lanes in ascending order.
    always_comb begin
        taken = valid_vec;
        for (int l = 0; l < INS_W; l++) begin
            slot_oh[l] = '0;
            found      = 1'b0;
            if (lane_req[l]) begin
                for (int s = 0; s < DEPTH; s++) begin
                    if (!found && !taken[s]) begin
                        slot_oh[l][s] = 1'b1;
                        taken[s]      = 1'b1;
                        found         = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/iq_age_matrix.sv
// Relative-age tracker and oldest-ready picker. Row s holds a bit for
// every slot older than s. A newly written slot is younger than all
// occupants and than lower lanes of the same cycle. Assumes ready_vec
// is zero for free slots, which masks stale rows.
module iq_age_matrix #(
    parameter int DEPTH = 16,
    parameter int INS_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            valid_vec,
    input  logic [INS_W-1:0][DEPTH-1:0] slot_oh,
    input  logic [DEPTH-1:0]            ready_vec,
    output logic [DEPTH-1:0]            grant
);
    logic [DEPTH-1:0][DEPTH-1:0] older;
    logic [DEPTH-1:0][DEPTH-1:0] row_new;
    logic [DEPTH-1:0]            ins_mask;
    logic [DEPTH-1:0]            lower;

    // Build the row each written slot receives.
    always_comb begin
        ins_mask = '0;
        row_new  = '0;
        lower    = '0;
        for (int l = 0; l < INS_W; l++) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (slot_oh[l][s]) row_new[s] = valid_vec | lower;
            end
            ins_mask = ins_mask | slot_oh[l];
            lower    = lower | slot_oh[l];
        end
    end

    // Update rows: written slots take a new row, others forget reused columns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (ins_mask[s]) older[s] <= row_new[s];
                else             older[s] <= older[s] & ~ins_mask;
            end
        end
    end

    // A ready slot wins when no ready slot is older than it.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_pick
            assign grant[g] = ready_vec[g] & ~|(older[g] & ready_vec);
        end
    endgenerate
endmodule

// File: rtl/iq_age_issue.sv
// Issue queue top: accepts up to INS_W micro-ops per cycle, wakes their
// sources from the wakeup bus and issues the oldest ready one each cycle.
// Assumes the consumer always takes the issued op in the same cycle.
module iq_age_issue
    import iq_pkg::*;
#(
    parameter int DEPTH           = 16,
    parameter int INS_W           = 4,
    parameter int WAKE_N          = 2,
    parameter bit ALLOW_ADDR_ONLY = 1'b1,
    localparam int TAG_W          = IQ_TAG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INS_W-1:0]        ins_valid,
    input  logic [INS_W*TAG_W-1:0]  ins_src0,
    input  logic [INS_W-1:0]        ins_src0_rdy,
    input  logic [INS_W*TAG_W-1:0]  ins_src1,
    input  logic [INS_W-1:0]        ins_src1_rdy,
    input  logic [INS_W*TAG_W-1:0]  ins_dst,
    input  logic [INS_W-1:0]        ins_mem,
    input  logic                    mem_q_full,
    input  logic [WAKE_N-1:0]       wake_valid,
    input  logic [WAKE_N*TAG_W-1:0] wake_tag,
    output logic                    full,
    output logic                    iss_valid,
    output logic [TAG_W-1:0]        iss_dst,
    output logic                    iss_addr_only
);
    logic [DEPTH-1:0]            valid_vec;
    logic [DEPTH-1:0]            ready_vec;
    logic [DEPTH-1:0]            grant;
    logic [INS_W-1:0]            lane_req;
    logic [INS_W-1:0][DEPTH-1:0] slot_oh;
    logic [DEPTH-1:0]            slot_wr;
    iq_uop_t                     lane_uop [INS_W];
    iq_uop_t                     slot_uop [DEPTH];
    iq_uop_t                     cur_uop  [DEPTH];
    logic                        mem_ok;

    assign mem_ok = ALLOW_ADDR_ONLY && mem_q_full;

    // Qualify each lane and pack its fields.
    always_comb begin
        for (int l = 0; l < INS_W; l++) begin
            lane_req[l]           = ins_valid[l] & ~full & (~ins_mem[l] | mem_ok);
            lane_uop[l].src0      = ins_src0[l*TAG_W +: TAG_W];
            lane_uop[l].src0_rdy  = ins_src0_rdy[l];
            lane_uop[l].src1      = ins_src1[l*TAG_W +: TAG_W];
            lane_uop[l].src1_rdy  = ins_src1_rdy[l];
            lane_uop[l].dst       = ins_dst[l*TAG_W +: TAG_W];
            lane_uop[l].addr_only = ins_mem[l];
        end
    end

    iq_alloc #(.DEPTH(DEPTH), .INS_W(INS_W)) u_alloc (
        .valid_vec (valid_vec),
        .lane_req  (lane_req),
        .slot_oh   (slot_oh),
        .full      (full)
    );

    // Route each lane's op to the slot it was given.
    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            slot_wr[s]  = 1'b0;
            slot_uop[s] = '0;
            for (int l = 0; l < INS_W; l++) begin
                if (slot_oh[l][s]) begin
                    slot_wr[s]  = 1'b1;
                    slot_uop[s] = lane_uop[l];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            iq_entry #(.WAKE_N(WAKE_N)) u_entry (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr         (slot_wr[g]),
                .wr_uop     (slot_uop[g]),
                .clr        (grant[g]),
                .wake_valid (wake_valid),
                .wake_tag   (wake_tag),
                .valid      (valid_vec[g]),
                .ready      (ready_vec[g]),
                .uop        (cur_uop[g])
            );
        end
    endgenerate

    iq_age_matrix #(.DEPTH(DEPTH), .INS_W(INS_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .slot_oh   (slot_oh),
        .ready_vec (ready_vec),
        .grant     (grant)
    );

    // Select the issued op's fields with the one-hot grant.
    always_comb begin
        iss_valid     = |grant;
        iss_dst       = '0;
        iss_addr_only = 1'b0;
        for (int s = 0; s < DEPTH; s++) begin
            if (grant[s]) begin
                iss_dst       = iss_dst | cur_uop[s].dst;
                iss_addr_only = iss_addr_only | cur_uop[s].addr_only;
            end
        end
    end
endmodule

// File: rtl/iq_age_issue_chk.sv
// Protocol checker for the issue queue, attached by bind. Watches
// occupancy, readiness and the grant vector.
module iq_age_issue_chk #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] ready_vec,
    input logic [DEPTH-1:0] grant,
    input logic             full,
    input logic             iss_valid
);
    // R9
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(ready_vec & valid_vec)) == '0);

    // R9
    issued_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> ((valid_vec & $past(grant)) == '0));

    // R6
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !iss_valid) |=> $stable(valid_vec));
endmodule

bind iq_age_issue iq_age_issue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .ready_vec (ready_vec),
    .grant     (grant),
    .full      (full),
    .iss_valid (iss_valid)
);

// File: tb/iq_age_issue_test.sv
// Directed bench: one task per scenario. Inputs change at the falling
// edge and outputs are sampled just after it.
module iq_age_issue_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int INS_W  = 4;
    localparam int WAKE_N = 2;
    localparam int TW     = 6;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [INS_W-1:0]      ins_valid, ins_src0_rdy, ins_src1_rdy, ins_mem;
    logic [INS_W*TW-1:0]   ins_src0, ins_src1, ins_dst;
    logic                  mem_q_full;
    logic [WAKE_N-1:0]     wake_valid;
    logic [WAKE_N*TW-1:0]  wake_tag;
    logic                  full, iss_valid, iss_addr_only;
    logic [TW-1:0]         iss_dst;

    int tests = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    iq_age_issue #(.DEPTH(DEPTH), .INS_W(INS_W), .WAKE_N(WAKE_N), .ALLOW_ADDR_ONLY(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_src0(ins_src0),
        .ins_src0_rdy(ins_src0_rdy), .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy),
        .ins_dst(ins_dst), .ins_mem(ins_mem), .mem_q_full(mem_q_full),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .full(full),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_addr_only(iss_addr_only)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = '0; ins_src0 = '0; ins_src1 = '0; ins_dst = '0;
        ins_src0_rdy = '0; ins_src1_rdy = '0; ins_mem = '0;
        wake_valid = '0; wake_tag = '0;
    endtask

    task automatic push(input int l, input int s0, input bit r0, input int s1, input bit r1,
                        input int dst, input bit mem);
        ins_valid[l] = 1'b1;
        ins_src0[l*TW +: TW] = TW'(s0); ins_src0_rdy[l] = r0;
        ins_src1[l*TW +: TW] = TW'(s1); ins_src1_rdy[l] = r1;
        ins_dst[l*TW +: TW]  = TW'(dst); ins_mem[l] = mem;
    endtask

    task automatic wake(input int p, input int tag);
        wake_valid[p] = 1'b1;
        wake_tag[p*TW +: TW] = TW'(tag);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic expect_iss(input string req, input int dst);
        chk(req, {31'd0, iss_valid}, 32'd1);
        chk(req, {26'd0, iss_dst}, 32'(dst));
    endtask

    task automatic t_reset();
        chk("R1 iss_valid", {31'd0, iss_valid}, 0);
        chk("R1 full", {31'd0, full}, 0);
    endtask

    task automatic t_lane_order();
        for (int l = 0; l < INS_W; l++) push(l, 0, 1, 0, 1, 10 + l, 0);
        step();
        for (int k = 0; k < INS_W; k++) begin
            expect_iss("R5 lane age", 10 + k);
            step();
        end
        chk("R9 drained", {31'd0, iss_valid}, 0);
    endtask

    task automatic t_age_not_slot();
        push(0, 0, 1, 0, 1, 30, 0);
        push(1, 5, 0, 0, 1, 31, 0);
        step();
        expect_iss("R3 first", 30);
        step();
        push(0, 6, 0, 0, 1, 32, 0);
        step();
        chk("R2 pending not issued", {31'd0, iss_valid}, 0);
        wake(0, 5); wake(1, 6); #1;
        chk("R4 not same cycle", {31'd0, iss_valid}, 0);
        step();
        expect_iss("R3 older in higher slot", 31);
        step();
        expect_iss("R3 younger in lower slot", 32);
        step();
        chk("R9 empty", {31'd0, iss_valid}, 0);
    endtask

    task automatic t_wake_on_write();
        push(0, 7, 0, 7, 0, 40, 0);
        wake(1, 7);
        step();
        expect_iss("R7 captured wakeup", 40);
        step();
    endtask

    task automatic t_one_source();
        push(0, 0, 1, 8, 0, 41, 0);
        step();
        chk("R2 one source pending", {31'd0, iss_valid}, 0);
        wake(0, 9);
        step();
        chk("R4 other tag ignored", {31'd0, iss_valid}, 0);
        wake(0, 8);
        step();
        expect_iss("R4 woken", 41);
        step();
    endtask

    task automatic t_full();
        for (int c = 0; c < 3; c++) begin
            for (int l = 0; l < INS_W; l++) push(l, 50, 0, 0, 1, c*INS_W + l, 0);
            step();
        end
        chk("R6 four free", {31'd0, full}, 0);
        push(0, 50, 0, 0, 1, 12, 0);
        step();
        chk("R6 full", {31'd0, full}, 1);
        push(0, 0, 1, 0, 1, 60, 0);
        step();
        chk("R6 write dropped", {31'd0, iss_valid}, 0);
        wake(0, 50);
        step();
        for (int k = 0; k <= 12; k++) begin
            expect_iss("R3 fill order", k);
            step();
            if (k == 0) chk("R6 full clears", {31'd0, full}, 0);
        end
        chk("R6 dropped never issues", {31'd0, iss_valid}, 0);
    endtask

    task automatic t_mem();
        mem_q_full = 1'b0;
        push(0, 0, 1, 0, 1, 3, 1);
        push(1, 0, 1, 0, 1, 4, 0);
        step();
        expect_iss("R8 plain accepted", 4);
        chk("R8 plain flag", {31'd0, iss_addr_only}, 0);
        step();
        chk("R8 mem refused", {31'd0, iss_valid}, 0);
        mem_q_full = 1'b1;
        push(0, 0, 1, 0, 1, 5, 1);
        step();
        expect_iss("R8 mem accepted", 5);
        chk("R8 address-only flag", {31'd0, iss_addr_only}, 1);
        step();
        mem_q_full = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        mem_q_full = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_lane_order();
        t_age_not_slot();
        t_wake_on_write();
        t_one_source();
        t_full();
        t_mem();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule